// File: doc/BRIEF.md
# Burst Address Demultiplexer for a Multiplexed Memory Bus

This block sits between a 16-line shared bus and a bank of DRAM. The bus carries address and control in two halves. When the row strobe rises, the bus word holds the upper address half, a bank number and a write flag. The block latches all three and enables the addressed bank for the rest of the tenure.

When the column strobe rises for the first time in a tenure, the block loads the column address from the bus. The column strobe is then pulsed three more times to make a four-word burst. On each of those pulses the two lowest column bits step forward by one in a counter, modulo 4, while the upper column bits stay latched. The result is a burst that stays inside an aligned four-word block. Each column strobe edge produces a single-cycle beat strobe to the memory array.

When both strobes are low, the bus carries arbitration traffic. The block goes idle and ignores the bus. A column strobe that arrives without the row strobe is reported as a protocol error and has no other effect. Both strobes are active-high and sampled on the clock, so edges are detected one clock after they appear.

Top module: `burst_addr_demux`

## Requirements
- R1: After reset, row_addr, col_addr, bank_en, wr_en, beat_stb and proto_err are all zero.
- R2: On a rising edge of ras, the block latches three fields from the bus: row_addr = bus_ad[12:0], the bank number from bus_ad[14:13], and the write flag from bus_ad[15] (1 = write). These take effect one clock after ras is sampled high.
- R3: While a tenure is active, bank_en is one-hot with bit N set for latched bank N. In idle, bank_en is zero.
- R4: The first rising edge of cas in a tenure loads col_addr from bus_ad[11:0]. Every rising edge of cas while ras is high raises beat_stb for exactly one clock.
- R5: Every later rising edge of cas in the same tenure adds 1 modulo 4 to col_addr[1:0]. col_addr[11:2] is held, and the bus value is ignored.
- R6: wr_en is high during an active tenure exactly when the latched write flag is 1, and is low in idle.
- R7: When ras and cas are both low, the block returns to idle. Bus activity in idle leaves row_addr and col_addr unchanged.
- R8: A rising edge of cas while ras is low raises proto_err for one clock. It produces no beat_stb and does not change col_addr.
- R9: A new ras edge starts a fresh tenure. Its first cas edge loads the column from the bus again and does not continue the previous count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_ad | input | 16 | Multiplexed address/control bus |
| ras | input | 1 | Row strobe, active high |
| cas | input | 1 | Column strobe, active high |
| row_addr | output | 13 | Latched row address |
| col_addr | output | 12 | Column address (upper bits latched, lower two bits counted) |
| bank_en | output | 4 | One-hot bank enable |
| wr_en | output | 1 | Write enable for the addressed bank |
| beat_stb | output | 1 | One-clock strobe per burst beat |
| proto_err | output | 1 | One-clock flag for cas without ras |

## Verification
The bench runs bursts whose starting column has low bits 00, 01, 10 and 11. This exposes a counter that saturates instead of wrapping: it would stall at 3 or carry into col_addr[2]. During the repeated column strobes the bus is driven with garbage. A design that reloads the column on every edge would therefore jump to that garbage instead of stepping by one. After each tenure, the bench changes the bus in idle and issues an orphan column strobe. A block that tracks the bus when idle, or that counts orphan strobes as beats, shows a changed address or a stray beat. Back-to-back tenures catch a first-edge flag that is not re-armed: such a design would continue counting from the old column.

// File: rtl/burst_addr_demux.sv
module burst_addr_demux #(
  parameter int BUS_W  = 16,
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int COL_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BUS_W-1:0]         bus_ad,
  input  logic                     ras,
  input  logic                     cas,
  output logic [ROW_W-1:0]         row_addr,
  output logic [COL_W-1:0]         col_addr,
  output logic [(1<<BANK_W)-1:0]   bank_en,
  output logic                     wr_en,
  output logic                     beat_stb,
  output logic                     proto_err
);
  localparam int NBANK  = 1 << BANK_W;
  localparam int BANK_L = ROW_W;
  localparam int WR_BIT = ROW_W + BANK_W;
  localparam int CNT_W  = 2;

  logic              ras_q, cas_q;
  logic              active, first_pend, wr_flag;
  logic [BANK_W-1:0] bank;

  wire ras_rise = ras & ~ras_q;
  wire cas_rise = cas & ~cas_q;
  wire idle_now = ~ras & ~cas;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q      <= 1'b0;
      cas_q      <= 1'b0;
      active     <= 1'b0;
      first_pend <= 1'b0;
      wr_flag    <= 1'b0;
      bank       <= '0;
      row_addr   <= '0;
      col_addr   <= '0;
      beat_stb   <= 1'b0;
      proto_err  <= 1'b0;
    end else begin
      ras_q     <= ras;
      cas_q     <= cas;
      beat_stb  <= 1'b0;
      proto_err <= 1'b0;
      if (ras_rise) begin
        active     <= 1'b1;
        first_pend <= 1'b1;
        row_addr   <= bus_ad[ROW_W-1:0];
        bank       <= bus_ad[BANK_L +: BANK_W];
        wr_flag    <= bus_ad[WR_BIT];
      end else if (idle_now) begin
        active     <= 1'b0;
        first_pend <= 1'b0;
      end
      if (cas_rise) begin
        if (ras && active) begin
          beat_stb <= 1'b1;
          if (first_pend) begin
            col_addr   <= bus_ad[COL_W-1:0];
            first_pend <= 1'b0;
          end else begin
            col_addr[CNT_W-1:0] <= col_addr[CNT_W-1:0] + CNT_W'(1);
          end
        end else if (!ras) begin
          proto_err <= 1'b1;
        end
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NBANK; gi++) begin : g_bank
      assign bank_en[gi] = active && (bank == BANK_W'(gi));
    end
  endgenerate

  assign wr_en = active & wr_flag;

  AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en)) else $error("bank_en not one-hot"); // R3

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_now && !ras_rise) |=> (bank_en == '0 && !wr_en)) else $error("idle did not clear"); // R7

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_rise && ras && active && !first_pend && !ras_rise) |=>
      (col_addr[CNT_W-1:0] == $past(col_addr[CNT_W-1:0]) + CNT_W'(1)) &&
      (col_addr[COL_W-1:CNT_W] == $past(col_addr[COL_W-1:CNT_W]))) else $error("column step wrong"); // R5

  AST_ORPHAN_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (!beat_stb && $stable(col_addr))) else $error("orphan cas had effect"); // R8

  AST_BEAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_stb |=> !beat_stb) else $error("beat longer than one clock"); // R4

  AST_WR_IN_TENURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (bank_en != '0)) else $error("write outside tenure"); // R6
endmodule

// File: tb/burst_addr_demux_bench.sv
module burst_addr_demux_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_ad = '0;
  logic        ras = 1'b0, cas = 1'b0;
  logic [12:0] row_addr;
  logic [11:0] col_addr;
  logic [3:0]  bank_en;
  logic        wr_en, beat_stb, proto_err;
  int errors = 0, total = 0;

  always #5 clk = ~clk;

  burst_addr_demux u_burst_addr_demux (
    .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .ras(ras), .cas(cas),
    .row_addr(row_addr), .col_addr(col_addr), .bank_en(bank_en),
    .wr_en(wr_en), .beat_stb(beat_stb), .proto_err(proto_err));

  localparam logic [31:0] VEC [4] = '{
    {16'h8123, 16'h0ABC},
    {16'h3FFF, 16'h0FFF},
    {16'hC555, 16'h0002},
    {16'h6AAA, 16'h0351}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tenure(input logic [15:0] rw, input logic [15:0] cw);
    logic [11:0] col;
    @(negedge clk); bus_ad = rw; ras = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R2 row", 32'(row_addr), 32'(rw[12:0]));
    check("R3 bank_en", 32'(bank_en), 32'(4'b1 << rw[14:13]));
    check("R6 wr_en", 32'(wr_en), 32'(rw[15]));
    bus_ad = cw; cas = 1'b1;
    @(negedge clk);
    check("R4 first beat", 32'(beat_stb), 32'd1);
    check("R4 col load", 32'(col_addr), 32'(cw[11:0]));
    col = cw[11:0];
    cas = 1'b0; bus_ad = ~cw;
    @(negedge clk);
    check("R4 beat one clock", 32'(beat_stb), 32'd0);
    for (int b = 1; b < 4; b++) begin
      cas = 1'b1; bus_ad = 16'h0F0F ^ 16'(b * 16'h1111);
      @(negedge clk);
      col[1:0] = col[1:0] + 2'd1;
      check("R5 step beat", 32'(beat_stb), 32'd1);
      check("R5 col step", 32'(col_addr), 32'(col));
      cas = 1'b0;
      @(negedge clk);
    end
    ras = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R3 idle bank_en", 32'(bank_en), 32'd0);
    check("R6 idle wr_en", 32'(wr_en), 32'd0);
    bus_ad = 16'hFFFF ^ rw;
    repeat (3) @(negedge clk);
    check("R7 row held", 32'(row_addr), 32'(rw[12:0]));
    check("R7 col held", 32'(col_addr), 32'(col));
    cas = 1'b1;
    @(negedge clk);
    check("R8 proto_err", 32'(proto_err), 32'd1);
    check("R8 no beat", 32'(beat_stb), 32'd0);
    check("R8 col unchanged", 32'(col_addr), 32'(col));
    cas = 1'b0;
    @(negedge clk);
    check("R8 err one clock", 32'(proto_err), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 row", 32'(row_addr), 32'd0);
    check("R1 col", 32'(col_addr), 32'd0);
    check("R1 bank_en", 32'(bank_en), 32'd0);
    check("R1 flags", {29'd0, wr_en, beat_stb, proto_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) tenure(VEC[i][31:16], VEC[i][15:0]);
    // R9: back-to-back tenures reload the column
    tenure(16'h2001, 16'h0443);
    tenure(16'hA002, 16'h0110);
    @(negedge clk); bus_ad = 16'h5F00; ras = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_ad = 16'h0123; cas = 1'b1;
    @(negedge clk);
    check("R9 fresh load", 32'(col_addr), 32'h123);
    cas = 1'b0; ras = 1'b0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule